// File: doc/BRIEF.md
# Seven-Register Bus Datapath

This block is the execution half of a small processor: a file of seven general registers tied to one ALU by two operand buses. A 14-bit control word arrives every clock. Two source fields each pick an operand, either one of the seven registers or the external data input. A five-bit operation field chooses what the ALU does with the two operands. A destination field picks at most one register to receive the result.

The ALU result is captured into the external output register on every rising edge, whatever the destination field or write enable says. A sequencer outside this block can therefore show a register, load a register from the input, or pass the input straight through, all with the transfer operation. Clearing a register takes a single word: XOR the register with itself and write the result back into it.

Top module: `bdp_datapath`

## Requirements
- R1: The control word `ctrl` holds the operand-A source in bits 13:11, the operand-B source in bits 10:8, the destination in bits 7:5 and the operation code in bits 4:0.
- R2: A source code of 1 to 7 places register Rn (n equal to the code) on that operand bus.
- R3: A source code of 0 places `din` on that operand bus.
- R4: On every rising edge that is not in reset, `dout` takes the ALU result of the control word and data present before that edge, so it has one cycle of latency.
- R5: When `we` is 1 and the destination code k is 1 to 7, Rk loads the ALU result on the same edge, and every other register keeps its value.
- R6: When the destination code is 0, or `we` is 0, no register changes, and `dout` is still updated as R4 states.
- R7: Arithmetic codes work modulo 256: 00000 passes A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1.
- R8: Logic codes: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A. XOR of a register with itself gives 0.
- R9: Shift codes: 10000 shifts A right by one and copies the old bit 7 into bit 7. 11000 shifts A left by one and fills bit 0 with zero.
- R10: Any operation code not listed in R7 to R9 passes A unchanged.
- R11: When `rst` is high at a rising edge, all seven registers and `dout` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Register write enable |
| ctrl | input | 14 | Control word: A source, B source, destination, operation |
| din | input | 8 | External data input, used by source code 0 |
| dout | output | 8 | Registered ALU result |

## Verification
The hardest fault to see from the ports is a write that lands in the wrong register or in a second register. `dout` only shows the result of the current word, so a bad register stays hidden until something reads it later through an operand bus. The stimulus deals with this in two ways. Random control words use all eight source codes and every destination code, so later words read back registers that earlier words wrote. Directed sequences load seven distinct values and then sweep every register through the transfer operation, both after writes with the enable off and after writes with destination 0. Self-XOR, sign-preserving shifts and wrap-around at 0x00 and 0xFF are forced with directed operands, because random data seldom reaches them.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_TSFA = 5'b00000,
    OP_INCA = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DECA = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_COMA = 5'b01110,
    OP_SHRA = 5'b10000,
    OP_SHLA = 5'b11000
  } alu_op_e;

endpackage

// File: rtl/bdp_regfile.sv
module bdp_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              wr_en,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  q
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= '0;
      end else if (wr_en[i]) begin
        q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/bdp_src_mux.sv
module bdp_src_mux #(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = 3
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [DATA_W-1:0]            ext,
  input  logic [NREG-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]            bus
);

  always_comb begin
    bus = ext;
    for (int i = 1; i <= NREG; i++) begin
      if (sel == SEL_W'(i)) begin
        bus = regs[i-1];
      end
    end
  end

endmodule

// File: rtl/bdp_dst_dec.sv
module bdp_dst_dec #(
  parameter int NREG  = 7,
  parameter int SEL_W = 3
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [NREG-1:0]   hot
);

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hot[i] = en && (sel == SEL_W'(i + 1));
  end

endmodule

// File: rtl/bdp_alu.sv
module bdp_alu
  import bdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]    op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  y
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      OP_TSFA: y = a;
      OP_INCA: y = a + ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DECA: y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_COMA: y = ~a;
      OP_SHRA: y = {a[DATA_W-1], a[DATA_W-1:1]};
      OP_SHLA: y = {a[DATA_W-2:0], 1'b0};
      default: y = a;
    endcase
  end

endmodule

// File: rtl/bdp_datapath.sv
module bdp_datapath
  import bdp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 7,
  parameter int SEL_W  = $clog2(NREG + 1),
  parameter int CW     = 3 * SEL_W + OP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CW-1:0]      ctrl,
  input  logic [DATA_W-1:0]  din,
  output logic [DATA_W-1:0]  dout
);

  localparam int A_HI = CW - 1;
  localparam int B_HI = CW - 1 - SEL_W;
  localparam int D_HI = CW - 1 - 2 * SEL_W;

  logic [SEL_W-1:0]             sel_a, sel_b, sel_d;
  logic [OP_W-1:0]              op;
  logic [NREG-1:0][DATA_W-1:0]  regs;
  logic [DATA_W-1:0]            bus_a, bus_b, result;
  logic [NREG-1:0]              wr_hot;

  assign sel_a = ctrl[A_HI -: SEL_W];
  assign sel_b = ctrl[B_HI -: SEL_W];
  assign sel_d = ctrl[D_HI -: SEL_W];
  assign op    = ctrl[OP_W-1:0];

  bdp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_hot), .wr_data(result), .q(regs)
  );

  bdp_src_mux #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_a (
    .sel(sel_a), .ext(din), .regs(regs), .bus(bus_a)
  );

  bdp_src_mux #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_mux_b (
    .sel(sel_b), .ext(din), .regs(regs), .bus(bus_b)
  );

  bdp_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op), .a(bus_a), .b(bus_b), .y(result)
  );

  bdp_dst_dec #(.NREG(NREG), .SEL_W(SEL_W)) u_dec (
    .en(we), .sel(sel_d), .hot(wr_hot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else begin
      dout <= result;
    end
  end

endmodule

// File: rtl/bdp_datapath_chk.sv
module bdp_datapath_chk
  import bdp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int CW     = 14
) (
  input logic               clk,
  input logic               rst,
  input logic               we,
  input logic [CW-1:0]      ctrl,
  input logic [DATA_W-1:0]  din,
  input logic [DATA_W-1:0]  dout
);

  logic [SEL_W-1:0] c_a, c_b, c_d;
  logic [OP_W-1:0]  c_op;
  assign c_a  = ctrl[CW-1 -: SEL_W];
  assign c_b  = ctrl[CW-1-SEL_W -: SEL_W];
  assign c_d  = ctrl[CW-1-2*SEL_W -: SEL_W];
  assign c_op = ctrl[OP_W-1:0];

  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (dout == '0));

  p_input_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_TSFA && c_a == '0) |=> (dout == $past(din)));

  p_self_xor_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_XOR && c_a == c_b) |=> (dout == '0));

  p_inc_input_r7: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_INCA && c_a == '0) |=> (dout == $past(din) + DATA_W'(1)));

  p_com_input_r8: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_COMA && c_a == '0) |=> (dout == ~$past(din)));

  p_write_readback_r5: assert property (@(posedge clk) disable iff (rst)
    (we && c_d != '0) ##1 (c_op == OP_TSFA && c_a == $past(c_d))
      |=> (dout == $past(dout)));

endmodule

bind bdp_datapath bdp_datapath_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .we(we), .ctrl(ctrl), .din(din), .dout(dout)
);

// File: tb/bdp_datapath_test.sv
`timescale 1ns/1ps
module bdp_datapath_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we  = 1'b0;
  logic [13:0] ctrl = '0;
  logic [7:0]  din  = '0;
  logic [7:0]  dout;

  int tests = 0;
  int fails = 0;
  logic [7:0] m [1:7];

  localparam logic [4:0] T_TSFA = 5'b00000, T_INCA = 5'b00001, T_ADD = 5'b00010,
    T_SUB = 5'b00101, T_DECA = 5'b00110, T_AND = 5'b01000, T_OR = 5'b01010,
    T_XOR = 5'b01100, T_COMA = 5'b01110, T_SHRA = 5'b10000, T_SHLA = 5'b11000;

  always #2 clk = ~clk;

  bdp_datapath uut (.clk(clk), .rst(rst), .we(we), .ctrl(ctrl), .din(din), .dout(dout));

  function automatic logic [7:0] model_alu(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      T_INCA: return a + 8'd1;
      T_ADD:  return a + b;
      T_SUB:  return a - b;
      T_DECA: return a - 8'd1;
      T_AND:  return a & b;
      T_OR:   return a | b;
      T_XOR:  return a ^ b;
      T_COMA: return ~a;
      T_SHRA: return {a[7], a[7:1]};
      T_SHLA: return {a[6:0], 1'b0};
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      T_TSFA, T_INCA, T_ADD, T_SUB, T_DECA: return "R7";
      T_AND, T_OR, T_XOR, T_COMA:           return "R8";
      T_SHRA, T_SHLA:                       return "R9";
      default:                              return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input int sa, input int sb, input int sd,
                      input logic [4:0] op, input logic [7:0] d, input logic w);
    logic [7:0] a, b, e;
    a = (sa == 0) ? d : m[sa];
    b = (sb == 0) ? d : m[sb];
    e = model_alu(op, a, b);
    @(negedge clk);
    ctrl = {sa[2:0], sb[2:0], sd[2:0], op};
    din  = d;
    we   = w;
    @(posedge clk);
    #1;
    if (w && sd != 0) m[sd] = e;
    check(tag, dout, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ctrl = {3'd0, 3'd0, 3'd0, T_COMA}; din = 8'h5A; we = 1'b1;
    @(posedge clk); #1;
    check("R11 dout", dout, 8'h00);
    @(negedge clk);
    rst = 1'b0; we = 1'b0;
    for (int i = 1; i <= 7; i++) m[i] = 8'h00;
    for (int i = 1; i <= 7; i++) step("R11 reg", i, 0, 0, T_TSFA, 8'hFF, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 1; i <= 7; i++) m[i] = 8'h00;
    repeat (2) @(posedge clk);
    do_reset();

    // Load distinct values through the input path (R3, R5)
    for (int i = 1; i <= 7; i++) step("R3 load", 0, 0, i, T_TSFA, 8'(8'h11 * i), 1'b1);
    for (int i = 1; i <= 7; i++) step("R2 read", i, 0, 0, T_TSFA, 8'h00, 1'b0);
    // Field layout: A=R2, B=R3, D=R1 (R1)
    step("R1 fields", 2, 3, 1, T_ADD, 8'h00, 1'b1);
    step("R5 readback", 1, 0, 0, T_TSFA, 8'h00, 1'b0);
    step("R2 B bus", 0, 6, 0, T_OR, 8'h00, 1'b0);
    // Writes with enable off / destination zero (R6)
    step("R6 we off", 0, 0, 4, T_TSFA, 8'hC3, 1'b0);
    step("R6 dest0", 0, 0, 0, T_TSFA, 8'h3C, 1'b1);
    for (int i = 1; i <= 7; i++) step("R6 sweep", i, 0, 0, T_TSFA, 8'h00, 1'b0);
    // Self XOR clears (R8)
    step("R8 self xor", 5, 5, 5, T_XOR, 8'h00, 1'b1);
    step("R8 cleared", 5, 0, 0, T_TSFA, 8'h00, 1'b0);
    // Arithmetic corners (R7)
    step("R7 inc wrap", 0, 0, 0, T_INCA, 8'hFF, 1'b0);
    step("R7 dec wrap", 0, 0, 0, T_DECA, 8'h00, 1'b0);
    step("R7 sub neg", 3, 0, 0, T_SUB, 8'h55, 1'b0);
    // Shifts (R9)
    step("R9 shr sign", 0, 0, 0, T_SHRA, 8'h80, 1'b0);
    step("R9 shr pos", 0, 0, 0, T_SHRA, 8'h7F, 1'b0);
    step("R9 shl", 0, 0, 0, T_SHLA, 8'h81, 1'b0);
    step("R8 com", 7, 0, 0, T_COMA, 8'h00, 1'b0);
    // Undefined codes (R10)
    step("R10 undef", 0, 0, 0, 5'b11111, 8'hA7, 1'b0);
    step("R10 undef reg", 6, 2, 3, 5'b00011, 8'h00, 1'b1);
    step("R5 undef wb", 3, 0, 0, T_TSFA, 8'h00, 1'b0);
    // R4: latency, output tracks each word
    step("R4 seq a", 0, 0, 0, T_TSFA, 8'h01, 1'b0);
    step("R4 seq b", 0, 0, 0, T_TSFA, 8'h02, 1'b0);

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] op;
      int k;
      k = $urandom_range(0, 11);
      case (k)
        0: op = T_TSFA;  1: op = T_INCA;  2: op = T_ADD;  3: op = T_SUB;
        4: op = T_DECA;  5: op = T_AND;   6: op = T_OR;   7: op = T_XOR;
        8: op = T_COMA;  9: op = T_SHRA;  10: op = T_SHLA;
        default: op = 5'($urandom_range(0, 31));
      endcase
      step(tag_of(op), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           op, 8'($urandom), 1'($urandom));
    end
    for (int i = 1; i <= 7; i++) step("R5 final sweep", i, 0, 0, T_TSFA, 8'h00, 1'b0);

    do_reset();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule